// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is the digital sequencer that moves a chip between its power modes: running, suspended (after a USB idle period), standby, and hard power-down. A timer driven by a reference tick watches a USB activity strobe and raises an idle interrupt once the bus has been quiet for a programmable number of ticks. Firmware can then ask for suspend. The controller accepts the request only if no veto condition holds. When it accepts, it first runs a contact-card shut-off handshake and only then enters suspend.

While the chip sleeps, a maskable set of wake flags is watched. The suspend set and the standby set differ only in which host link counts. The first enabled flag that rises returns the controller to the running mode, latches the cause in a sticky write-1-to-clear register and emits a one-cycle wake pulse. A standby that was forced by over-temperature ends on its own once every enabled temperature flag has cleared.

Hard power-down follows the external active-low reset pin and a supply-low flag, both passed through two-flop synchronizers. It overrides every other transition. Entry and exit use different rules, so a low supply can hold the chip down even when automatic entry is disabled. Clock enables and regulator enables are decoded from the mode.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After system reset `mode_o` is 0 (running), `idle_irq_o`, `wake_pulse_o`, `susp_nak_o` and `wake_cause_o` are 0, all clock and regulator enables are 1, and `main_ldo_lp_o` is 0.
- R2: `idle_irq_o` goes high once `IDLE_TICKS` ticks have been counted with no `usb_act_i`, and stays high. Any `usb_act_i` clears it on the next cycle and restarts the count.
- R3: In mode 0, an accepted `susp_req_i` moves to mode 1 (card shut-off, `card_deact_o`=1) on the next cycle. The controller then moves to mode 2 (suspend) on the cycle after `card_done_i` is seen.
- R4: A suspend request is refused while any of these holds: `host_busy_i`; any enabled flag of the suspend wake set is already high; enable bit 2 (RF field) is set while `rf_det_on_i` is 0; `pvdd_ok_i` is 0. A refusal gives a one-cycle `susp_nak_o` on the next cycle and leaves the mode at 0.
- R5: Wake flag indices are: 0 serial host link, 1 USB resume, 2 RF field, 3 GPIO, 4 card insert/remove, 5 auxiliary UART interrupt, 6 wake counter, 7 overcurrent, 8 overvoltage. Suspend (mode 2) ignores index 0. Standby (mode 3) ignores index 1. A wake returns to mode 0 on the next cycle, pulses `wake_pulse_o` for one cycle and sets the matching cause bits.
- R6: A wake flag whose `wake_en_i` bit is 0 neither wakes the controller nor vetoes suspend.
- R7: In mode 0, any temperature flag that is high and enabled enters mode 3 on the next cycle. That standby ends when no enabled temperature flag remains high, setting cause bit 9. Over-temperature has priority over firmware requests.
- R8: `stby_req_i` in mode 0 enters mode 3. A standby entered this way is not ended by temperature recovery.
- R9: Hard power-down (mode 4) is entered from any mode when `rst_pin_n_i` is low, or when `supply_low_i` and `auto_hpd_en_i` are both high. Because of the synchronizer, the mode changes at the third rising edge after the input changes.
- R10: Mode 4 is left for mode 0 only when the synchronized pin is high and the synchronized supply-low flag is 0, whatever `auto_hpd_en_i` is.
- R11: Modes 0 and 1 drive all clock and regulator enables to 1 with `main_ldo_lp_o`=0. Modes 2 and 3 drive only clock bit 0 and regulator bit 0, with `main_ldo_lp_o`=0. Mode 4 drives all clocks off, only regulator bit 0 on, and `main_ldo_lp_o`=1.
- R12: Cause bits stay set until a 1 is written to the same bit of `cause_clr_i`. A new wake on a bit in the same cycle as its clear keeps that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick_i | input | 1 | Reference tick for the idle timer |
| usb_act_i | input | 1 | USB bus activity strobe |
| idle_irq_o | output | 1 | USB idle interrupt |
| susp_req_i | input | 1 | Firmware suspend request |
| stby_req_i | input | 1 | Firmware standby request |
| host_busy_i | input | 1 | Host transfer in progress |
| rf_det_on_i | input | 1 | RF field detector is powered |
| pvdd_ok_i | input | 1 | Peripheral supply present |
| wake_src_i | input | 9 | Raw wake flags, indices as in R5 |
| wake_en_i | input | 9 | Per-flag wake enables |
| temp_hot_i | input | NTEMP | Temperature above limit, per sensor |
| temp_en_i | input | NTEMP | Per-sensor enable |
| card_done_i | input | 1 | Card shut-off complete |
| card_deact_o | output | 1 | Card shut-off request |
| rst_pin_n_i | input | 1 | External active-low reset pin (asynchronous) |
| supply_low_i | input | 1 | Supply below 2.3 V flag (asynchronous) |
| auto_hpd_en_i | input | 1 | Enable automatic power-down on low supply |
| cause_clr_i | input | 10 | Write-1-to-clear for cause bits |
| wake_cause_o | output | 10 | Sticky wake cause, bit 9 = temperature recovery |
| wake_pulse_o | output | 1 | One-cycle wake pulse |
| susp_nak_o | output | 1 | One-cycle suspend refusal |
| mode_o | output | 3 | 0 run, 1 card off, 2 suspend, 3 standby, 4 power-down |
| clk_en_o | output | NCLK | Clock enables |
| ldo_en_o | output | NLDO | Regulator enables, bit 0 = main regulator |
| main_ldo_lp_o | output | 1 | Main regulator low-power mode |

## Verification
Requests, wake flags, card completion and cause clears all act at the first rising edge. Mode, refusal pulse, wake pulse and cause are read half a cycle after that edge. The reset pin and the supply flag act one edge late through each of two flops, so the mode changes at the third edge. The bench checks the unchanged mode after two edges, then the new mode after the third. Idle interrupt timing is counted tick by tick from the edge that saw the last activity strobe. Mode-derived enables are read in the same half-cycle as the mode.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_CARDOFF = 3'd1,
    PM_SUSPEND = 3'd2,
    PM_STANDBY = 3'd3,
    PM_HPD     = 3'd4
  } pm_mode_t;

  localparam int NWS      = 9;
  localparam int NCAUSE   = NWS + 1;
  localparam int WK_HOST  = 0;
  localparam int WK_USB   = 1;
  localparam int WK_RF    = 2;
  localparam int WK_TEMP  = NWS;

  localparam logic [NWS-1:0] SUSP_SET = ~(NWS'(1) << WK_HOST);
  localparam logic [NWS-1:0] STBY_SET = ~(NWS'(1) << WK_USB);
endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= d_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int IDLE_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic act_i,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = act_i || (tick_i && (cnt_q != LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (act_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign idle_o = (cnt_q == LIMIT);

  assert_act_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> !idle_o);
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && !act_i) |=> idle_o);
endmodule

// File: rtl/pm_wake_capture.sv
module pm_wake_capture #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o,
  output logic         pulse_o
);
  logic [N-1:0] cause_q, cause_d, set_v;
  logic         pulse_q;

  assign set_v = go_i ? hit_i : '0;

  always_comb begin
    cause_d = (cause_q & ~clr_i) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
      pulse_q <= go_i;
    end
  end

  assign cause_o = cause_q;
  assign pulse_o = pulse_q;

  assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v == '0 && clr_i == '0) |=> $stable(cause_q));
  assert_pulse_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cause_q != '0));
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
  import pm_pkg::*;
#(
  parameter int IDLE_TICKS = 3000,
  parameter int NTEMP      = 2,
  parameter int NCLK       = 4,
  parameter int NLDO       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              usb_act_i,
  output logic              idle_irq_o,
  input  logic              susp_req_i,
  input  logic              stby_req_i,
  input  logic              host_busy_i,
  input  logic              rf_det_on_i,
  input  logic              pvdd_ok_i,
  input  logic [8:0]        wake_src_i,
  input  logic [8:0]        wake_en_i,
  input  logic [NTEMP-1:0]  temp_hot_i,
  input  logic [NTEMP-1:0]  temp_en_i,
  input  logic              card_done_i,
  output logic              card_deact_o,
  input  logic              rst_pin_n_i,
  input  logic              supply_low_i,
  input  logic              auto_hpd_en_i,
  input  logic [9:0]        cause_clr_i,
  output logic [9:0]        wake_cause_o,
  output logic              wake_pulse_o,
  output logic              susp_nak_o,
  output logic [2:0]        mode_o,
  output logic [NCLK-1:0]   clk_en_o,
  output logic [NLDO-1:0]   ldo_en_o,
  output logic              main_ldo_lp_o
);
  pm_mode_t          state_q, state_d;
  logic              ot_q, ot_d, nak_q, nak_d;
  logic [1:0]        sync_v;
  logic              pin_s, low_s, hpd_enter, hot_any, veto, wake_go;
  logic [NWS-1:0]    src_on, sleep_set;
  logic [NCAUSE-1:0] wake_hit;

  pm_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({supply_low_i, rst_pin_n_i}), .q_o(sync_v)
  );
  assign pin_s = sync_v[0];
  assign low_s = sync_v[1];

  pm_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .act_i(usb_act_i), .idle_o(idle_irq_o)
  );

  assign hpd_enter = !pin_s || (low_s && auto_hpd_en_i);
  assign hot_any   = |(temp_hot_i & temp_en_i);
  assign src_on    = wake_src_i & wake_en_i;
  assign veto      = host_busy_i || (|(src_on & SUSP_SET)) ||
                     (wake_en_i[WK_RF] && !rf_det_on_i) || !pvdd_ok_i;

  always_comb begin
    sleep_set = '0;
    if (state_q == PM_SUSPEND)      sleep_set = SUSP_SET;
    else if (state_q == PM_STANDBY) sleep_set = STBY_SET;
    wake_hit = {(state_q == PM_STANDBY) && ot_q && !hot_any, src_on & sleep_set};
  end

  assign wake_go = (state_q == PM_SUSPEND || state_q == PM_STANDBY) &&
                   !hpd_enter && (|wake_hit);

  always_comb begin
    state_d = state_q;
    ot_d    = ot_q;
    nak_d   = 1'b0;
    if (hpd_enter) begin
      state_d = PM_HPD;
    end else begin
      case (state_q)
        PM_RUN: begin
          if (hot_any) begin
            state_d = PM_STANDBY;
            ot_d    = 1'b1;
          end else if (susp_req_i) begin
            if (veto) nak_d   = 1'b1;
            else      state_d = PM_CARDOFF;
          end else if (stby_req_i) begin
            state_d = PM_STANDBY;
            ot_d    = 1'b0;
          end
        end
        PM_CARDOFF: if (card_done_i) state_d = PM_SUSPEND;
        PM_SUSPEND, PM_STANDBY: begin
          if (wake_go) begin
            state_d = PM_RUN;
            ot_d    = 1'b0;
          end
        end
        PM_HPD: begin
          if (pin_s && !low_s) begin
            state_d = PM_RUN;
            ot_d    = 1'b0;
          end
        end
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      ot_q    <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ot_q    <= ot_d;
      nak_q   <= nak_d;
    end
  end

  pm_wake_capture #(.N(NCAUSE)) u_wake (
    .clk(clk), .rst_n(rst_n), .go_i(wake_go), .hit_i(wake_hit),
    .clr_i(cause_clr_i), .cause_o(wake_cause_o), .pulse_o(wake_pulse_o)
  );

  always_comb begin
    clk_en_o      = '1;
    ldo_en_o      = '1;
    main_ldo_lp_o = 1'b0;
    case (state_q)
      PM_SUSPEND, PM_STANDBY: begin
        clk_en_o = NCLK'(1);
        ldo_en_o = NLDO'(1);
      end
      PM_HPD: begin
        clk_en_o      = '0;
        ldo_en_o      = NLDO'(1);
        main_ldo_lp_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign card_deact_o = (state_q == PM_CARDOFF);
  assign susp_nak_o   = nak_q;
  assign mode_o       = state_q;

  assert_hpd_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> (state_q == PM_HPD));
  assert_hpd_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_HPD && !(pin_s && !low_s)) |=> (state_q == PM_HPD));
  assert_susp_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PM_SUSPEND) |-> ($past(state_q) == PM_CARDOFF && $past(card_done_i)));
  assert_nak_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nak_q |-> (state_q == PM_RUN));
  assert_wake_from_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_o |-> (state_q == PM_RUN &&
      ($past(state_q) == PM_SUSPEND || $past(state_q) == PM_STANDBY)));
  assert_hot_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && hot_any && !hpd_enter) |=> (state_q == PM_STANDBY));
endmodule

// File: tb/pm_mode_ctrl_tb.sv
module pm_mode_ctrl_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tick, usb_act, idle_irq, susp_req, stby_req, host_busy;
  logic       rf_on, pvdd_ok, card_done, card_deact, rst_pin_n, supply_low, auto_hpd;
  logic [8:0] wsrc, wen;
  logic [1:0] thot, ten;
  logic [9:0] cclr, cause;
  logic       wpulse, nak, lp;
  logic [2:0] mode;
  logic [3:0] clken;
  logic [2:0] ldoen;

  int checks = 0;
  int errors = 0;

  pm_mode_ctrl #(.IDLE_TICKS(8), .NTEMP(2), .NCLK(4), .NLDO(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .usb_act_i(usb_act), .idle_irq_o(idle_irq),
    .susp_req_i(susp_req), .stby_req_i(stby_req), .host_busy_i(host_busy),
    .rf_det_on_i(rf_on), .pvdd_ok_i(pvdd_ok), .wake_src_i(wsrc), .wake_en_i(wen),
    .temp_hot_i(thot), .temp_en_i(ten), .card_done_i(card_done), .card_deact_o(card_deact),
    .rst_pin_n_i(rst_pin_n), .supply_low_i(supply_low), .auto_hpd_en_i(auto_hpd),
    .cause_clr_i(cclr), .wake_cause_o(cause), .wake_pulse_o(wpulse), .susp_nak_o(nak),
    .mode_o(mode), .clk_en_o(clken), .ldo_en_o(ldoen), .main_ldo_lp_o(lp)
  );

  // {host_busy, rf_on, pvdd_ok, wake_src[8:0], wake_en[8:0], accept}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 9'h000, 9'h000, 1'b1},
    {1'b1, 1'b1, 1'b1, 9'h000, 9'h000, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h008, 9'h008, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h008, 9'h000, 1'b1},
    {1'b0, 1'b0, 1'b1, 9'h000, 9'h004, 1'b0},
    {1'b0, 1'b0, 1'b1, 9'h000, 9'h000, 1'b1},
    {1'b0, 1'b1, 1'b0, 9'h000, 9'h000, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h001, 9'h001, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 1; usb_act = 0; susp_req = 0; stby_req = 0; host_busy = 0;
    rf_on = 1; pvdd_ok = 1; card_done = 0; rst_pin_n = 1; supply_low = 0; auto_hpd = 0;
    wsrc = '0; wen = '0; thot = '0; ten = '0; cclr = '0;
    step(3);
    rst_n = 1;
    step(1);

    // R1 reset state
    chk("R1 mode", 32'(mode), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 enables", {clken, ldoen, lp, wpulse, nak}, {4'hF, 3'h7, 1'b0, 1'b0, 1'b0});

    // R2 idle timer with tick every cycle
    usb_act = 1; step(1); usb_act = 0;
    chk("R2 cleared by activity", 32'(idle_irq), 0);
    step(7);
    chk("R2 not yet idle", 32'(idle_irq), 0);
    step(1);
    chk("R2 idle raised", 32'(idle_irq), 1);
    step(3);
    chk("R2 idle held", 32'(idle_irq), 1);
    usb_act = 1; step(1); usb_act = 0;
    chk("R2 idle cleared", 32'(idle_irq), 0);

    // R3 R4 R6 table of suspend requests
    for (int i = 0; i < 8; i++) begin
      host_busy = VEC[i][21]; rf_on = VEC[i][20]; pvdd_ok = VEC[i][19];
      wsrc = VEC[i][18:10]; wen = VEC[i][9:1];
      susp_req = 1; step(1); susp_req = 0;
      if (VEC[i][0]) begin
        chk($sformatf("R3 row %0d card off", i), {mode, card_deact, nak}, {3'd1, 1'b1, 1'b0});
        host_busy = 0; rf_on = 1; pvdd_ok = 1; wsrc = '0;
        step(2);
        chk($sformatf("R3 row %0d waits card", i), 32'(mode), 1);
        card_done = 1; step(1); card_done = 0;
        chk($sformatf("R3 row %0d suspend", i), {mode, card_deact}, {3'd2, 1'b0});
        chk($sformatf("R11 row %0d sleep enables", i), {clken, ldoen, lp}, {4'h1, 3'h1, 1'b0});
        wen = '0; wsrc = 9'h1FF; step(2);
        chk($sformatf("R6 row %0d disabled ignored", i), 32'(mode), 2);
        wen = 9'h001; wsrc = 9'h001; step(1);
        chk($sformatf("R5 row %0d host ignored in suspend", i), 32'(mode), 2);
        wen = 9'h008; wsrc = 9'h008; step(1);
        chk($sformatf("R5 row %0d gpio wake", i), {mode, wpulse}, {3'd0, 1'b1});
        chk($sformatf("R5 row %0d cause", i), 32'(cause), 32'h008);
        wsrc = '0; wen = '0; cclr = 10'h008; step(1); cclr = '0;
        chk($sformatf("R12 row %0d cleared", i), {cause, wpulse}, {10'h000, 1'b0});
      end else begin
        chk($sformatf("R4 row %0d refused", i), {mode, nak}, {3'd0, 1'b1});
        step(1);
        chk($sformatf("R4 row %0d nak one cycle", i), {mode, nak}, {3'd0, 1'b0});
      end
      host_busy = 0; rf_on = 1; pvdd_ok = 1; wsrc = '0; wen = '0;
    end

    // R8 firmware standby, no temperature wake
    stby_req = 1; step(1); stby_req = 0;
    chk("R8 standby entered", 32'(mode), 3);
    chk("R11 standby enables", {clken, ldoen, lp}, {4'h1, 3'h1, 1'b0});
    ten = 2'b11; step(3);
    chk("R8 no temperature recovery", 32'(mode), 3);
    wen = 9'h1FF; wsrc = 9'h002; step(2);
    chk("R5 usb ignored in standby", 32'(mode), 3);
    wsrc = 9'h001; step(1);
    chk("R5 host wakes standby", {mode, wpulse, cause}, {3'd0, 1'b1, 10'h001});
    wsrc = '0; wen = '0; step(1);
    chk("R12 sticky cause", {cause, wpulse}, {10'h001, 1'b0});
    cclr = 10'h001; step(1); cclr = '0;
    chk("R12 write one clears", 32'(cause), 0);

    // R7 over-temperature standby and recovery
    ten = 2'b01; thot = 2'b10; step(2);
    chk("R7 disabled sensor ignored", 32'(mode), 0);
    ten = 2'b11; stby_req = 1; step(1); stby_req = 0;
    chk("R7 hot entry", 32'(mode), 3);
    step(3);
    chk("R7 stays while hot", 32'(mode), 3);
    thot = 2'b00; cclr = 10'h200; step(1); cclr = '0;
    chk("R7 recovery wake", {mode, wpulse}, {3'd0, 1'b1});
    chk("R12 set wins over clear", 32'(cause), 32'h200);
    cclr = 10'h200; step(1); cclr = '0; ten = '0;

    // R9 R10 hard power-down via reset pin
    rst_pin_n = 0; step(2);
    chk("R9 pin not yet synced", 32'(mode), 0);
    step(1);
    chk("R9 pin power-down", 32'(mode), 4);
    chk("R11 power-down enables", {clken, ldoen, lp}, {4'h0, 3'h1, 1'b1});
    supply_low = 1; rst_pin_n = 1; step(4);
    chk("R10 supply low holds down", 32'(mode), 4);
    supply_low = 0; step(2);
    chk("R10 exit not yet synced", 32'(mode), 4);
    step(1);
    chk("R10 exit to run", {mode, clken, lp}, {3'd0, 4'hF, 1'b0});

    // R9 supply-low entry needs auto enable
    supply_low = 1; step(4);
    chk("R9 no auto entry", 32'(mode), 0);
    auto_hpd = 1; step(1);
    chk("R9 auto entry", 32'(mode), 4);
    auto_hpd = 0; step(3);
    chk("R10 low supply keeps down without auto", 32'(mode), 4);
    supply_low = 0; step(3);
    chk("R10 leaves with supply restored", 32'(mode), 0);

    // R9 overrides suspend path
    susp_req = 1; step(1); susp_req = 0;
    chk("R3 card off before override", 32'(mode), 1);
    rst_pin_n = 0; step(3);
    chk("R9 overrides card off", 32'(mode), 4);
    rst_pin_n = 1; step(3);
    chk("R10 run after override", 32'(mode), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule